// File: doc/BRIEF.md
# Packed 52-bit multiply-accumulate unit

This block is a lane-parallel integer datapath for multi-precision arithmetic that keeps big numbers in 52-bit limbs. Each 64-bit lane carries an accumulator word and two multiplicand words. The low 52 bits of the two multiplicands are multiplied as unsigned values into a 104-bit product. One half of that product is zero-extended to 64 bits and added to the accumulator. A mode input picks the half, so one pass of each mode gives the low and high limb contributions of a limb product.

The lane count is a parameter (2 or 4). The result bus always has room for four lanes, and every lane above the active count reads zero. Operations enter through a valid/ready handshake. They pass through three pipeline stages: partial products, product reduction, and half selection with the add. The result comes out with a valid flag, and a downstream ready input can stall it.

Top module: `madd52_unit`

## Requirements
- R1: Lane l uses bits [64*l+63 : 64*l] of each input bus for l below LANES. Result lanes at index LANES and above (bits above 64*LANES-1 of res_o) are always zero.
- R2: Only bits 51:0 of each multiplicand lane enter the product, as unsigned values. Bits 63:52 of either multiplicand have no effect on the result.
- R3: With hi_sel_i = 1 the lane result is acc + zero-extended product bits 103:52.
- R4: With hi_sel_i = 0 the lane result is acc + zero-extended product bits 51:0.
- R5: The 64-bit add wraps modulo 2^64 and signals no carry.
- R6: Each lane computes independently. Values in one lane never affect another lane.
- R7: An operation is accepted on a rising edge where in_valid_i and in_ready_o are both high. With out_ready_i held high, out_valid_o rises after the third rising edge, counting the accepting edge as the first.
- R8: While out_valid_o is high and out_ready_i is low, in_ready_o is low, and on the next edge out_valid_o stays high and res_o is unchanged.
- R9: Results leave on edges where out_valid_o and out_ready_i are both high. They leave in acceptance order, and each accepted operation leaves exactly once.
- R10: While rst_ni is low, all pipeline valid bits clear. After reset, out_valid_o is low and in_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Operation offered |
| in_ready_o | output | 1 | Unit can take an operation |
| hi_sel_i | input | 1 | 1: add product bits 103:52, 0: add product bits 51:0 |
| acc_i | input | 64*LANES | Accumulator lanes |
| mul_a_i | input | 64*LANES | First multiplicand lanes |
| mul_b_i | input | 64*LANES | Second multiplicand lanes |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Downstream takes the result |
| res_o | output | 256 | Result lanes, unused lanes zero |

## Verification
An operation can be accepted on the same edge that the output stage is being drained. An output stall can also arrive on the same edge that new operations are still being offered. The bench provokes both by driving out_ready_i from a random pattern that is low about a quarter of the time, while operations arrive back to back or with short random gaps. A scoreboard fed at every acceptance checks each result as it leaves. During a stall the bench checks that the result stays unchanged and that in_ready_o is low. At the end it checks that the number of results that left equals the number of operations accepted.

// File: rtl/madd52_pkg.sv
package madd52_pkg;
  localparam int unsigned LANE_W    = 64;
  localparam int unsigned OP_W      = 52;
  localparam int unsigned PROD_W    = 2 * OP_W;
  localparam int unsigned MAX_LANES = 4;
  localparam int unsigned STAGES    = 3;
endpackage

// File: rtl/madd52_pipe_ctrl.sv
module madd52_pipe_ctrl
  import madd52_pkg::*;
#(
  parameter int unsigned DEPTH = STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic             out_ready_i,
  output logic             adv_o,
  output logic [DEPTH-1:0] vld_o
);
  logic [DEPTH-1:0] vld_q;
  logic             adv;

  // whole pipe moves together; only a held output blocks it
  assign adv        = !vld_q[DEPTH-1] || out_ready_i;
  assign adv_o      = adv;
  assign in_ready_o = adv;
  assign vld_o      = vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q[0] <= 1'b0;
    else if (adv) vld_q[0] <= in_valid_i;
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_vld
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vld_q[s] <= 1'b0;
      else if (adv) vld_q[s] <= vld_q[s-1];
    end
  end

  assert_hold_on_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q[DEPTH-1] && !out_ready_i) |=> vld_q[DEPTH-1]);

  assert_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vld_q[DEPTH-1]) |-> $past(vld_q[DEPTH-2]));
endmodule

// File: rtl/madd52_lane.sv
module madd52_lane
  import madd52_pkg::*;
#(
  parameter int unsigned CHUNKS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [OP_W-1:0]   a_i,
  input  logic [OP_W-1:0]   b_i,
  input  logic [LANE_W-1:0] acc_i,
  input  logic              sel_s2_i,
  output logic [LANE_W-1:0] res_o
);
  localparam int unsigned CW  = OP_W / CHUNKS;
  localparam int unsigned PPW = CW + OP_W;
  localparam int unsigned PAD = LANE_W - OP_W;

  // stage 1: partial products of multiplier chunks
  logic [PPW-1:0]    pp_q [CHUNKS];
  logic [LANE_W-1:0] acc_s1_q;

  for (genvar k = 0; k < CHUNKS; k++) begin : g_pp
    always_ff @(posedge clk_i) begin
      if (adv_i) pp_q[k] <= PPW'(a_i[k*CW +: CW]) * PPW'(b_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (adv_i) acc_s1_q <= acc_i;
  end

  // stage 2: reduce to full product
  logic [PROD_W-1:0] prod_sum;
  logic [PROD_W-1:0] prod_s2_q;
  logic [LANE_W-1:0] acc_s2_q;

  always_comb begin
    prod_sum = '0;
    for (int k = 0; k < CHUNKS; k++) begin
      prod_sum = prod_sum + (PROD_W'(pp_q[k]) << (k * CW));
    end
  end

  always_ff @(posedge clk_i) begin
    if (adv_i) begin
      prod_s2_q <= prod_sum;
      acc_s2_q  <= acc_s1_q;
    end
  end

  // stage 3: pick half, accumulate with wrap
  logic [OP_W-1:0]   half;
  logic [LANE_W-1:0] res_q;

  assign half = sel_s2_i ? prod_s2_q[PROD_W-1:OP_W] : prod_s2_q[OP_W-1:0];

  always_ff @(posedge clk_i) begin
    if (adv_i) res_q <= acc_s2_q + {{PAD{1'b0}}, half};
  end

  assign res_o = res_q;

  assert_addend_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> ((res_q - $past(acc_s2_q)) >> OP_W) == '0);
endmodule

// File: rtl/madd52_unit.sv
module madd52_unit
  import madd52_pkg::*;
#(
  parameter int unsigned LANES  = 2,
  parameter int unsigned CHUNKS = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        in_valid_i,
  output logic                        in_ready_o,
  input  logic                        hi_sel_i,
  input  logic [LANES*LANE_W-1:0]     acc_i,
  input  logic [LANES*LANE_W-1:0]     mul_a_i,
  input  logic [LANES*LANE_W-1:0]     mul_b_i,
  output logic                        out_valid_o,
  input  logic                        out_ready_i,
  output logic [MAX_LANES*LANE_W-1:0] res_o
);
  localparam int unsigned ACT_W = LANES * LANE_W;
  localparam int unsigned TOP_W = LANE_W - OP_W;

  logic              adv;
  logic [STAGES-1:0] vld;
  logic              sel_s1_q, sel_s2_q;

  madd52_pipe_ctrl #(.DEPTH(STAGES)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .out_ready_i (out_ready_i),
    .adv_o       (adv),
    .vld_o       (vld)
  );

  always_ff @(posedge clk_i) begin
    if (adv) begin
      sel_s1_q <= hi_sel_i;
      sel_s2_q <= sel_s1_q;
    end
  end

  logic [ACT_W-1:0]         res_act;
  logic [2*LANES*TOP_W-1:0] top_bits;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign top_bits[2*l*TOP_W +: 2*TOP_W] =
      {mul_a_i[l*LANE_W+OP_W +: TOP_W], mul_b_i[l*LANE_W+OP_W +: TOP_W]};

    madd52_lane #(.CHUNKS(CHUNKS)) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .adv_i    (adv),
      .a_i      (mul_a_i[l*LANE_W +: OP_W]),
      .b_i      (mul_b_i[l*LANE_W +: OP_W]),
      .acc_i    (acc_i[l*LANE_W +: LANE_W]),
      .sel_s2_i (sel_s2_q),
      .res_o    (res_act[l*LANE_W +: LANE_W])
    );
  end

  // multiplicand bits 63:52 are dropped by definition
  logic unused_top;
  assign unused_top = ^top_bits;

  if (LANES < MAX_LANES) begin : g_pad
    assign res_o = {{(MAX_LANES*LANE_W-ACT_W){1'b0}}, res_act};
  end else begin : g_full
    assign res_o = res_act;
  end

  assign out_valid_o = vld[STAGES-1];

  assert_stable_on_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> $stable(res_o));

  assert_ready_low_on_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);
endmodule

// File: tb/madd52_unit_tb_top.sv
module madd52_unit_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int LANES = 2;
  localparam int AW    = LANES * 64;
  localparam int MW    = 4 * 64;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          in_valid_i = 1'b0;
  logic          in_ready_o;
  logic          hi_sel_i = 1'b0;
  logic [AW-1:0] acc_i = '0, mul_a_i = '0, mul_b_i = '0;
  logic          out_valid_o;
  logic          out_ready_i = 1'b0;
  logic [MW-1:0] res_o;

  always #2.5 clk_i = ~clk_i;

  madd52_unit #(.LANES(LANES)) dut_i (
    .clk_i, .rst_ni, .in_valid_i, .in_ready_o, .hi_sel_i,
    .acc_i, .mul_a_i, .mul_b_i, .out_valid_o, .out_ready_i, .res_o
  );

  int    n_chk = 0, n_fail = 0, n_in = 0, n_out = 0;
  string cur_tag = "R4";
  logic [MW-1:0] exp_q[$];
  string         tag_q[$];
  logic          prev_stall = 1'b0;
  logic [MW-1:0] prev_res;

  function automatic logic [63:0] ref_lane(logic [63:0] acc, logic [63:0] a,
                                            logic [63:0] b, logic hi);
    logic [127:0] p;
    p = {76'd0, a[51:0]} * {76'd0, b[51:0]};
    return hi ? acc + {12'd0, p[103:52]} : acc + {12'd0, p[51:0]};
  endfunction

  function automatic logic [MW-1:0] ref_vec(logic [AW-1:0] acc, logic [AW-1:0] a,
                                             logic [AW-1:0] b, logic hi);
    logic [MW-1:0] v = '0;
    for (int l = 0; l < LANES; l++)
      v[l*64 +: 64] = ref_lane(acc[l*64 +: 64], a[l*64 +: 64], b[l*64 +: 64], hi);
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [MW-1:0] act,
                       input logic [MW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: sees settled inputs of the coming edge
  always @(negedge clk_i) begin
    #1;
    if (rst_ni) begin
      if (prev_stall)
        check(out_valid_o && res_o == prev_res, "R8", res_o, prev_res);
      prev_stall = out_valid_o && !out_ready_i;
      prev_res   = res_o;
      if (prev_stall) check(!in_ready_o, "R8", MW'(in_ready_o), '0);
      if (out_valid_o && out_ready_i) begin
        n_out++;
        check(res_o[MW-1:AW] == '0, "R1", res_o, '0);
        if (exp_q.size() == 0) check(1'b0, "R9", res_o, '0);
        else begin
          logic [MW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(res_o == e, t, res_o, e);
        end
      end
      if (in_valid_i && in_ready_o) begin
        n_in++;
        exp_q.push_back(ref_vec(acc_i, mul_a_i, mul_b_i, hi_sel_i));
        tag_q.push_back(cur_tag);
      end
    end
  end

  task automatic send(input logic [AW-1:0] acc, input logic [AW-1:0] a,
                      input logic [AW-1:0] b, input logic hi, input string tag,
                      input int rdy_pct);
    bit took;
    acc_i = acc; mul_a_i = a; mul_b_i = b; hi_sel_i = hi; cur_tag = tag;
    in_valid_i = 1'b1;
    do begin
      out_ready_i = (int'($urandom % 100) < rdy_pct);
      #1;
      took = in_ready_o;
      @(negedge clk_i);
    end while (!took);
    in_valid_i = 1'b0;
  endtask

  task automatic idle(input int n, input int rdy_pct);
    in_valid_i = 1'b0;
    repeat (n) begin
      out_ready_i = (int'($urandom % 100) < rdy_pct);
      @(negedge clk_i);
    end
  endtask

  function automatic logic [AW-1:0] rnd_vec();
    logic [AW-1:0] v;
    for (int l = 0; l < LANES; l++) v[l*64 +: 64] = {$urandom, $urandom};
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] ones52, a_up, b_up;
    int unused_seed;
    unused_seed = $urandom(32'd2024);
    ones52 = {12'd0, {52{1'b1}}};
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!out_valid_o, "R10", MW'(out_valid_o), '0);
    check(in_ready_o, "R10", MW'(in_ready_o), MW'(1));

    // R7 latency with an empty pipe
    out_ready_i = 1'b1;
    acc_i = {2{64'd7}}; mul_a_i = {2{ones52}}; mul_b_i = {2{ones52}};
    hi_sel_i = 1'b1; cur_tag = "R3"; in_valid_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    check(!out_valid_o, "R7", MW'(out_valid_o), '0);
    @(negedge clk_i);
    check(!out_valid_o, "R7", MW'(out_valid_o), '0);
    @(negedge clk_i);
    check(out_valid_o, "R7", MW'(out_valid_o), MW'(1));
    idle(3, 100);

    // R2 upper multiplicand bits ignored: compare against clean operands
    a_up = {12'hfff, 52'd3};
    b_up = {12'habc, 52'd5};
    send({2{64'd100}}, {2{a_up}}, {2{b_up}}, 1'b0, "R2", 100);
    send({2{64'd100}}, {2{64'd3}}, {2{64'd5}}, 1'b0, "R2", 100);
    idle(4, 100);
    check(res_o[63:0] == 64'd115, "R2", res_o, MW'(115));

    // R4 all-ones low half is 1; R3 high half is 2^52-2
    send('0, {2{ones52}}, {2{ones52}}, 1'b0, "R4", 100);
    idle(4, 100);
    check(res_o[63:0] == 64'd1, "R4", res_o, MW'(1));
    send('0, {2{ones52}}, {2{ones52}}, 1'b1, "R3", 100);
    idle(4, 100);
    check(res_o[63:0] == {12'd0, {51{1'b1}}, 1'b0}, "R3", res_o,
          MW'({12'd0, {51{1'b1}}, 1'b0}));

    // R5 wrap: all-ones accumulator plus 1 gives 0
    send({2{64'hffff_ffff_ffff_ffff}}, {2{ones52}}, {2{ones52}}, 1'b0, "R5", 100);
    idle(4, 100);
    check(res_o[AW-1:0] == '0, "R5", res_o, '0);

    // R6 lanes independent: lane 0 all zero, lane 1 heavy
    send({64'h1234_5678_9abc_def0, 64'd0}, {ones52, 64'd0},
         {64'h000a_bcde_f012_3456, 64'hffff_ffff_ffff_ffff}, 1'b1, "R6", 100);
    idle(4, 100);
    check(res_o[63:0] == 64'd0, "R6", res_o, '0);

    // back-to-back and stalled random traffic
    for (int i = 0; i < 2500; i++) begin
      logic hi;
      hi = $urandom % 2;
      send(rnd_vec(), rnd_vec(), rnd_vec(), hi, hi ? "R3" : "R4", 75);
      if ($urandom % 4 == 0) idle(int'($urandom % 3), 75);
    end
    idle(12, 100);
    check(n_in == n_out && exp_q.size() == 0, "R9", MW'(n_out), MW'(n_in));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule